// File: doc/BRIEF.md
# Serial Register Front End for a Frequency Synthesizer

This block receives 24-bit programming words on a three-wire serial port (serial clock, serial data, load enable) and turns them into the register state that a frequency-synthesizer control core needs. The three serial lines are asynchronous to the system clock, so each one passes through a two-flop synchroniser and an edge detector. Data is taken in most significant bit first on each rising serial clock. On the rising edge of load enable, the two lowest bits of the word choose which latch receives it.

The block exports the decoded fields that the rest of the synthesizer uses: prescaler code, reference divide value, swallow and main counter values, band-select clock divide and charge-pump gain. It also runs two timed actions from the write stream. Each write to the counter latch starts a band-select interval, and a tune-disconnect output stays high for that interval. A power-down request is either immediate or gated, and the gated form waits for edges of the reference-divider output. A ready flag shows when the expected start-up order of writes has been completed.

Top module: `synth_ser_regif`

## Requirements
- R1: Serial data is shifted in MSB first on each rising serial clock. On a rising load enable, word bits [1:0] route the word: 00 to the control latch, 01 to the reference latch, 10 to the counter latch, 11 to the test latch.
- R2: A reference-latch write sets ref_div_o from bits [15:2] and bs_div_sel_o from bits [21:20].
- R3: A counter-latch write sets swallow_o from bits [6:2] and main_div_o from bits [20:8].
- R4: A control-latch write sets prescaler_o from bits [23:22].
- R5: A test-latch write changes no output.
- R6: cp_gain_o takes control bit 10 or counter bit 21, whichever of these latches was written last.
- R7: Each counter-latch write raises tune_disc_o for five band-select clocks and restarts the band-select divider. One band-select clock is 1, 2, 4 or 8 reference-divider ticks, selected by bs_div_sel_o = 0, 1, 2 or 3.
- R8: A control write with bit 20 = 1 and bit 21 = 0 powers the block down as soon as the word is latched.
- R9: A control write with bit 20 = 1 and bit 21 = 1 raises pwr_down_o only after the second reference-divider tick that follows the write.
- R10: chip_en_i low forces pwr_down_o high, whatever bits 20 and 21 hold.
- R11: While powered down, writes still update the latches. The band-select interval is cleared, and it cannot start.
- R12: ready_o rises after a reference write, then a control write, then a counter write. A control or counter write out of that order sends the sequence back to its start. Once high, ready_o stays high until reset.
- R13: After reset all decoded fields are zero, and ready_o, tune_disc_o and pwr_down_o (with chip_en_i high) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial clock |
| ser_data_i | input | 1 | Asynchronous serial data |
| ser_le_i | input | 1 | Asynchronous load enable |
| chip_en_i | input | 1 | Chip enable; low forces power-down |
| rdiv_tick_i | input | 1 | One-cycle strobe per rising edge of the reference-divider output |
| prescaler_o | output | 2 | Prescaler select code |
| ref_div_o | output | 14 | Reference divide value |
| swallow_o | output | 5 | Swallow counter value |
| main_div_o | output | 13 | Main counter value |
| bs_div_sel_o | output | 2 | Band-select clock divide select |
| cp_gain_o | output | 1 | Charge-pump gain select |
| pwr_down_o | output | 1 | Power-down; forces dividers to load state and resets lock detect |
| tune_disc_o | output | 1 | Tune line disconnected during band select |
| ready_o | output | 1 | Start-up write order completed |

## Verification
The bench measures the band-select interval at divide 1 and divide 4, sampling one tick before the expected end and one tick after it. A timer that does not restart its divider, or that counts ticks instead of band-select clocks, would drop the output early or late. The gated power-down is probed after one tick and again after two, which catches a design that applies it at once or ignores it. The gain bit is written alternately through both latches, which exposes a design where one latch always wins. Out-of-order start-up writes, an all-ones test-latch word and writes made while powered down cover the sequence tracker, address decode and hold-off paths.

// File: rtl/synth_regif_pkg.sv
package synth_regif_pkg;

    localparam int WORD_W    = 24;
    localparam int REF_W     = 14;
    localparam int SWL_W     = 5;
    localparam int MAIN_W    = 13;
    localparam int BSSEL_W   = 2;
    localparam int PRE_W     = 2;
    localparam int BS_CYCLES = 5;
    localparam int PD_EDGES  = 2;
    localparam int BSPRE_W   = (1 << BSSEL_W) - 1;

    // field positions
    localparam int CTRL_GAIN_BIT   = 10;
    localparam int CTRL_PDREQ_BIT  = 20;
    localparam int CTRL_PDGATE_BIT = 21;
    localparam int CTRL_PRE_LSB    = 22;
    localparam int REF_VAL_LSB     = 2;
    localparam int REF_BSSEL_LSB   = 20;
    localparam int NC_SWL_LSB      = 2;
    localparam int NC_MAIN_LSB     = 8;
    localparam int NC_GAIN_BIT     = 21;

    typedef enum logic [1:0] {
        DST_CTRL = 2'b00,
        DST_REF  = 2'b01,
        DST_NCNT = 2'b10,
        DST_TEST = 2'b11
    } dest_e;

    typedef enum logic [1:0] {
        SEQ_WAIT_REF,
        SEQ_WAIT_CTRL,
        SEQ_WAIT_NCNT,
        SEQ_READY
    } seq_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             pd_gate;
        logic             pd_req;
        logic             gain;
    } ctrl_fields_t;

    function automatic dest_e word_dest(input logic [WORD_W-1:0] w);
        return dest_e'(w[1:0]);
    endfunction

    function automatic logic [BSPRE_W-1:0] bs_mask(input logic [BSSEL_W-1:0] sel);
        logic [BSPRE_W-1:0] m;
        m = '0;
        for (int i = 0; i < BSPRE_W; i++) begin
            if (i < int'(sel)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic ctrl_fields_t ctrl_decode(input logic [WORD_W-1:0] w);
        ctrl_fields_t f;
        f.pre     = w[CTRL_PRE_LSB +: PRE_W];
        f.pd_gate = w[CTRL_PDGATE_BIT];
        f.pd_req  = w[CTRL_PDREQ_BIT];
        f.gain    = w[CTRL_GAIN_BIT];
        return f;
    endfunction

endpackage

// File: rtl/synth_ser_sync.sv
module synth_ser_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_line
            logic s1, s2, s3;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                    s3 <= 1'b0;
                end else begin
                    s1 <= async_i[g];
                    s2 <= s1;
                    s3 <= s2;
                end
            end
            assign lvl_o[g]  = s2;
            assign rise_o[g] = s2 & ~s3;
        end
    endgenerate
endmodule

// File: rtl/synth_ser_shift.sv
module synth_ser_shift #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst)           word_o <= '0;
        else if (shift_en) word_o <= {word_o[W-2:0], bit_i};
    end
endmodule

// File: rtl/synth_bs_timer.sv
module synth_bs_timer
    import synth_regif_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               hold,
    input  logic               tick,
    input  logic [BSSEL_W-1:0] sel,
    output logic               active_o
);
    localparam int CNT_W = $clog2(BS_CYCLES);

    logic [BSPRE_W-1:0] pre_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [BSPRE_W-1:0] mask;
    logic               bs_edge;

    assign mask    = bs_mask(sel);
    assign bs_edge = tick && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            active_o <= 1'b0;
            pre_q    <= '0;
            cnt_q    <= '0;
        end else if (start) begin
            active_o <= 1'b1;
            pre_q    <= '0;
            cnt_q    <= '0;
        end else if (active_o && tick) begin
            if (bs_edge) begin
                pre_q <= '0;
                if (cnt_q == CNT_W'(BS_CYCLES - 1)) begin
                    active_o <= 1'b0;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/synth_pd_ctrl.sv
module synth_pd_ctrl
    import synth_regif_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic pd_req,
    input  logic pd_gate,
    input  logic chip_en,
    input  logic tick,
    output logic pwr_down_o
);
    localparam int EW = $clog2(PD_EDGES + 1);

    logic          imm_q;
    logic          armed_q;
    logic          sync_dn_q;
    logic [EW-1:0] edge_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            imm_q     <= 1'b0;
            armed_q   <= 1'b0;
            sync_dn_q <= 1'b0;
            edge_q    <= '0;
        end else if (ctrl_wr) begin
            imm_q <= pd_req & ~pd_gate;
            if (pd_req && pd_gate) begin
                if (!sync_dn_q) begin
                    armed_q <= 1'b1;
                    edge_q  <= '0;
                end
            end else begin
                armed_q   <= 1'b0;
                sync_dn_q <= 1'b0;
            end
        end else if (armed_q && tick) begin
            if (edge_q == EW'(PD_EDGES - 1)) begin
                sync_dn_q <= 1'b1;
                armed_q   <= 1'b0;
            end else begin
                edge_q <= edge_q + 1'b1;
            end
        end
    end

    assign pwr_down_o = ~chip_en | imm_q | sync_dn_q;
endmodule

// File: rtl/synth_ser_regif.sv
module synth_ser_regif
    import synth_regif_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_clk_i,
    input  logic               ser_data_i,
    input  logic               ser_le_i,
    input  logic               chip_en_i,
    input  logic               rdiv_tick_i,
    output logic [PRE_W-1:0]   prescaler_o,
    output logic [REF_W-1:0]   ref_div_o,
    output logic [SWL_W-1:0]   swallow_o,
    output logic [MAIN_W-1:0]  main_div_o,
    output logic [BSSEL_W-1:0] bs_div_sel_o,
    output logic               cp_gain_o,
    output logic               pwr_down_o,
    output logic               tune_disc_o,
    output logic               ready_o
);
    logic [2:0]        s_lvl, s_rise;
    logic [WORD_W-1:0] word_q;
    logic              word_stb;
    dest_e             dest;
    logic              wr_ctrl, wr_ref, wr_ncnt;
    ctrl_fields_t      cf;
    seq_e              seq_q;

    synth_ser_sync #(.N(3)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_le_i, ser_data_i, ser_clk_i}),
        .lvl_o   (s_lvl),
        .rise_o  (s_rise)
    );

    synth_ser_shift #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (s_rise[0]),
        .bit_i    (s_lvl[1]),
        .word_o   (word_q)
    );

    assign word_stb = s_rise[2];
    assign dest     = word_dest(word_q);
    assign wr_ctrl  = word_stb && (dest == DST_CTRL);
    assign wr_ref   = word_stb && (dest == DST_REF);
    assign wr_ncnt  = word_stb && (dest == DST_NCNT);
    assign cf       = ctrl_decode(word_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prescaler_o  <= '0;
            ref_div_o    <= '0;
            swallow_o    <= '0;
            main_div_o   <= '0;
            bs_div_sel_o <= '0;
            cp_gain_o    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                prescaler_o <= cf.pre;
                cp_gain_o   <= cf.gain;
            end
            if (wr_ref) begin
                ref_div_o    <= word_q[REF_VAL_LSB +: REF_W];
                bs_div_sel_o <= word_q[REF_BSSEL_LSB +: BSSEL_W];
            end
            if (wr_ncnt) begin
                swallow_o  <= word_q[NC_SWL_LSB +: SWL_W];
                main_div_o <= word_q[NC_MAIN_LSB +: MAIN_W];
                cp_gain_o  <= word_q[NC_GAIN_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SEQ_WAIT_REF;
        end else if (seq_q != SEQ_READY) begin
            if (wr_ref)
                seq_q <= SEQ_WAIT_CTRL;
            else if (wr_ctrl)
                seq_q <= (seq_q == SEQ_WAIT_CTRL) ? SEQ_WAIT_NCNT : SEQ_WAIT_REF;
            else if (wr_ncnt)
                seq_q <= (seq_q == SEQ_WAIT_NCNT) ? SEQ_READY : SEQ_WAIT_REF;
        end
    end
    assign ready_o = (seq_q == SEQ_READY);

    synth_pd_ctrl u_pd (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (wr_ctrl),
        .pd_req     (cf.pd_req),
        .pd_gate    (cf.pd_gate),
        .chip_en    (chip_en_i),
        .tick       (rdiv_tick_i),
        .pwr_down_o (pwr_down_o)
    );

    synth_bs_timer u_bs (
        .clk      (clk),
        .rst      (rst),
        .start    (wr_ncnt),
        .hold     (pwr_down_o),
        .tick     (rdiv_tick_i),
        .sel      (bs_div_sel_o),
        .active_o (tune_disc_o)
    );
endmodule

// File: rtl/synth_ser_regif_chk.sv
module synth_ser_regif_chk
    import synth_regif_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               chip_en_i,
    input logic               word_stb,
    input logic [WORD_W-1:0]  word_q,
    input logic [PRE_W-1:0]   prescaler_o,
    input logic [REF_W-1:0]   ref_div_o,
    input logic [SWL_W-1:0]   swallow_o,
    input logic [MAIN_W-1:0]  main_div_o,
    input logic               cp_gain_o,
    input logic               pwr_down_o,
    input logic               tune_disc_o,
    input logic               ready_o
);
    p_async_pd_r8: assert property (@(posedge clk) disable iff (rst)
        (word_stb && word_q[1:0] == 2'b00 && word_q[CTRL_PDREQ_BIT] && !word_q[CTRL_PDGATE_BIT])
        |=> pwr_down_o);

    p_gain_last_r6: assert property (@(posedge clk) disable iff (rst)
        (word_stb && word_q[1:0] == 2'b10) |=> (cp_gain_o == $past(word_q[NC_GAIN_BIT])));

    p_test_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (word_stb && word_q[1:0] == 2'b11) |=>
        ($stable(ref_div_o) && $stable(swallow_o) && $stable(main_div_o)
         && $stable(prescaler_o) && $stable(cp_gain_o)));

    p_ce_forces_pd_r10: assert property (@(posedge clk) disable iff (rst)
        !chip_en_i |-> pwr_down_o);

    p_ready_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> ready_o);

    p_pd_blocks_tune_r11: assert property (@(posedge clk) disable iff (rst)
        pwr_down_o |=> !tune_disc_o);

    p_tune_from_ncnt_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tune_disc_o) |-> $past(word_stb && word_q[1:0] == 2'b10));
endmodule

bind synth_ser_regif synth_ser_regif_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .chip_en_i   (chip_en_i),
    .word_stb    (word_stb),
    .word_q      (word_q),
    .prescaler_o (prescaler_o),
    .ref_div_o   (ref_div_o),
    .swallow_o   (swallow_o),
    .main_div_o  (main_div_o),
    .cp_gain_o   (cp_gain_o),
    .pwr_down_o  (pwr_down_o),
    .tune_disc_o (tune_disc_o),
    .ready_o     (ready_o)
);

// File: tb/synth_ser_regif_tb.sv
module synth_ser_regif_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
    logic        ce = 1'b1;
    logic        tick = 1'b0;
    logic [1:0]  pre, bssel;
    logic [13:0] refd;
    logic [4:0]  swl;
    logic [12:0] mdiv;
    logic        gain, pdn, tune, rdy;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    synth_ser_regif dut_i (
        .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_data_i(sdat), .ser_le_i(sle),
        .chip_en_i(ce), .rdiv_tick_i(tick), .prescaler_o(pre), .ref_div_o(refd),
        .swallow_o(swl), .main_div_o(mdiv), .bs_div_sel_o(bssel), .cp_gain_o(gain),
        .pwr_down_o(pdn), .tune_disc_o(tune), .ready_o(rdy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) begin
            @(negedge clk); sdat = w[i];
            wait_n(3); sclk = 1'b1;
            wait_n(3); sclk = 1'b0;
        end
        wait_n(3); sle = 1'b1;
        wait_n(4); sle = 1'b0;
        wait_n(4);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            wait_n(2);
        end
    endtask

    function automatic logic [23:0] w_ref(input int r, input int sel);
        return 24'((sel << 20) | (r << 2) | 1);
    endfunction
    function automatic logic [23:0] w_ctrl(input int p, input int g, input int req, input int gate);
        return 24'((p << 22) | (gate << 21) | (req << 20) | (g << 10));
    endfunction
    function automatic logic [23:0] w_ncnt(input int a, input int b, input int g);
        return 24'((g << 21) | (b << 8) | (a << 2) | 2);
    endfunction

    task automatic do_reset();
        rst = 1'b1; wait_n(4); rst = 1'b0; wait_n(2);
    endtask

    task automatic t_reset_state();
        chk("R13 ref", int'(refd), 0);
        chk("R13 main", int'(mdiv), 0);
        chk("R13 ready", int'(rdy), 0);
        chk("R13 tune", int'(tune), 0);
        chk("R13 pwrdn", int'(pdn), 0);
    endtask

    task automatic t_startup_fields();
        send_word(w_ncnt(3, 9, 0));
        chk("R12 early N not ready", int'(rdy), 0);
        send_word(w_ref(14'h1234, 2));
        chk("R2 ref", int'(refd), 'h1234);
        chk("R2 bssel", int'(bssel), 2);
        chk("R1 routing ref", int'(mdiv), 9);
        send_word(w_ctrl(2, 1, 0, 0));
        chk("R4 pre", int'(pre), 2);
        chk("R6 gain ctrl", int'(gain), 1);
        chk("R12 not yet", int'(rdy), 0);
        send_word(w_ncnt(21, 4000, 0));
        chk("R3 swallow", int'(swl), 21);
        chk("R3 main", int'(mdiv), 4000);
        chk("R6 gain ncnt", int'(gain), 0);
        chk("R12 ready", int'(rdy), 1);
        chk("R7 tune on", int'(tune), 1);
    endtask

    task automatic t_bs_div4();
        ticks(19);
        chk("R7 div4 19 ticks", int'(tune), 1);
        ticks(1);
        chk("R7 div4 20 ticks", int'(tune), 0);
    endtask

    task automatic t_bs_div1();
        send_word(w_ref(100, 0));
        ticks(2);
        send_word(w_ncnt(1, 50, 1));
        chk("R6 gain ncnt1", int'(gain), 1);
        ticks(4);
        chk("R7 div1 4 ticks", int'(tune), 1);
        ticks(1);
        chk("R7 div1 5 ticks", int'(tune), 0);
        chk("R12 sticky", int'(rdy), 1);
    endtask

    task automatic t_test_latch();
        send_word(24'hFFFFFF);
        chk("R5 ref", int'(refd), 100);
        chk("R5 main", int'(mdiv), 50);
        chk("R5 pre", int'(pre), 2);
        chk("R5 gain", int'(gain), 1);
        chk("R5 tune", int'(tune), 0);
        chk("R5 pwrdn", int'(pdn), 0);
    endtask

    task automatic t_async_pd();
        send_word(w_ctrl(1, 0, 1, 0));
        chk("R8 async down", int'(pdn), 1);
        send_word(w_ref(77, 0));
        chk("R11 write while down", int'(refd), 77);
        send_word(w_ncnt(2, 60, 0));
        chk("R11 no tune while down", int'(tune), 0);
        chk("R11 N latched", int'(mdiv), 60);
        send_word(w_ctrl(1, 0, 0, 0));
        chk("R8 up again", int'(pdn), 0);
    endtask

    task automatic t_sync_pd();
        send_word(w_ctrl(1, 0, 1, 1));
        chk("R9 not immediate", int'(pdn), 0);
        ticks(1);
        chk("R9 one tick", int'(pdn), 0);
        ticks(1);
        chk("R9 two ticks", int'(pdn), 1);
        send_word(w_ctrl(1, 0, 0, 0));
        chk("R9 released", int'(pdn), 0);
    endtask

    task automatic t_chip_en();
        @(negedge clk); ce = 1'b0;
        @(negedge clk);
        chk("R10 ce low", int'(pdn), 1);
        ce = 1'b1;
        @(negedge clk);
        chk("R10 ce high", int'(pdn), 0);
    endtask

    task automatic t_out_of_order();
        do_reset();
        send_word(w_ref(5, 1));
        send_word(w_ncnt(1, 9, 0));
        send_word(w_ctrl(0, 0, 0, 0));
        send_word(w_ncnt(1, 9, 0));
        chk("R12 skipped ctrl", int'(rdy), 0);
        send_word(w_ref(5, 1));
        send_word(w_ctrl(0, 0, 0, 0));
        send_word(w_ncnt(1, 9, 0));
        chk("R12 proper order", int'(rdy), 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_startup_fields();
        t_bs_div4();
        t_bs_div1();
        t_test_latch();
        t_async_pd();
        t_sync_pd();
        t_chip_en();
        t_out_of_order();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end
endmodule